// File: doc/BRIEF.md
# Global Register Bank Switcher

This block holds the eight active global registers of a processor core, plus four storage banks behind them. It also holds the processor-state word that chooses which bank those globals belong to. When the state word is written, the block keeps only its implemented bits. It then takes the three bank-select bits from the old and new values and compares them. If they differ, it runs a copy sequence. The sequence first writes the active globals back into the storage of the bank being left. It then fills the active globals from the storage of the bank being entered. It moves one register per cycle and shows the whole sequence on a busy flag.

The core reads the active globals through a combinational read port and writes them through a write port. A feature input can turn off the alternate bank, so that its select bit is dropped from every incoming value. The state word is stored whether or not a copy follows. Interrupt logic outside the block uses the other state bits.

Top module: `gbank_switch`

## Requirements
- R1: A state write stores the value ANDed with 12'hF3F. Bits 6 and 7 always read back as zero on `stateRd`.
- R2: The select bits sit at bit 0 (alternate), bit 10 (MMU) and bit 11 (interrupt). `activeBank` reports 0 when all three are clear. It reports 1 for alternate only, 2 for MMU only and 3 for interrupt only.
- R3: Any combination of two or three select bits maps to bank 0, the normal bank.
- R4: While `altDisable` is high, bit 0 of a written value is cleared before the value is stored and before the select comparison.
- R5: A write whose select bits equal the stored ones starts no copy. Busy stays low, the active globals keep their values, and the state word still takes the new value.
- R6: On a switch, all active globals are first saved into the old bank. They are then replaced with the new bank's saved contents, so leaving a bank and returning to it later restores its values.
- R7: `busy` rises on the clock edge that accepts a switching write. It stays high for exactly 2*NUM_REGS cycles, which is 16 by default.
- R8: While `busy` is high, writes to the active globals and writes to the state word are ignored.
- R9: After reset, the state word is zero, `activeBank` is 0, `busy` is low, and every active and banked register is zero.
- R10: `regRdData` always shows the active register selected by `regRdIdx`. A write while idle appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stateWrEn | input | 1 | Write strobe for the state word |
| stateWrData | input | 12 | New state word |
| altDisable | input | 1 | Feature input that turns off the alternate bank |
| stateRd | output | 12 | Stored state word |
| activeBank | output | 2 | Bank currently selected by the stored state word |
| busy | output | 1 | Copy sequence in progress |
| regWrEn | input | 1 | Write strobe for an active global |
| regWrIdx | input | 3 | Active global to write |
| regWrData | input | 64 | Write data |
| regRdIdx | input | 3 | Active global to read |
| regRdData | output | 64 | Read data |

## Verification
The bench uses the default build: 64-bit registers and eight of them per bank. With this build the busy window is the full 16 cycles, and wide patterns show any register that was not copied or was copied into the wrong bank. A stable model in the bench follows every bank across a tour of the alternate, MMU, interrupt and normal banks. It also covers the invalid-select fallback, where saving and loading use the same bank. The model shows that values return intact after a round trip and that writes made in the middle of a copy change nothing.

// File: rtl/gbank_pkg.sv
package gbank_pkg;

  localparam int STATE_W   = 12;
  localparam int NUM_BANKS = 4;
  localparam int ALT_BIT   = 0;
  localparam int MMU_BIT   = 10;
  localparam int INTR_BIT  = 11;
  localparam logic [STATE_W-1:0] STATE_KEEP = 12'hF3F;
  localparam logic [STATE_W-1:0] SEL_MASK   = 12'hC01;

  typedef enum logic [1:0] {
    BANK_NORMAL = 2'd0,
    BANK_ALT    = 2'd1,
    BANK_MMU    = 2'd2,
    BANK_INTR   = 2'd3
  } bank_e;

  typedef struct packed {
    logic  saveEn;
    logic  loadEn;
    bank_e saveBank;
    bank_e loadBank;
  } strobe_t;

  function automatic bank_e decodeBank(input logic [STATE_W-1:0] s);
    case ({s[INTR_BIT], s[MMU_BIT], s[ALT_BIT]})
      3'b001:  return BANK_ALT;
      3'b010:  return BANK_MMU;
      3'b100:  return BANK_INTR;
      default: return BANK_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/gbank_ctrl.sv
module gbank_ctrl
  import gbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int STEP_W = $clog2(2 * NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  input  logic               altDisable,
  output logic [STATE_W-1:0] stateQ,
  output bank_e              curBank,
  output logic               busy,
  output strobe_t            strobes,
  output logic [IDX_W-1:0]   stepIdx
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(2 * NUM_REGS - 1);
  localparam logic [STEP_W-1:0] HALF_STEP = STEP_W'(NUM_REGS);

  logic [STATE_W-1:0] maskedVal;
  logic [STATE_W-1:0] newSel;
  logic [STATE_W-1:0] oldSel;
  logic               accept;
  logic               startSwitch;
  logic               busyQ;
  logic [STEP_W-1:0]  stepQ;
  logic [STEP_W-1:0]  stepOff;
  logic               savePhase;
  bank_e              saveBankQ;
  bank_e              loadBankQ;

  always_comb begin
    maskedVal = stateWrData & STATE_KEEP;
    if (altDisable) maskedVal[ALT_BIT] = 1'b0;
    newSel      = maskedVal & SEL_MASK;
    oldSel      = stateQ & SEL_MASK;
    accept      = stateWrEn && !busyQ;
    startSwitch = accept && (newSel != oldSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= '0;
      busyQ     <= 1'b0;
      stepQ     <= '0;
      saveBankQ <= BANK_NORMAL;
      loadBankQ <= BANK_NORMAL;
    end else begin
      if (accept) stateQ <= maskedVal;
      if (startSwitch) begin
        busyQ     <= 1'b1;
        stepQ     <= '0;
        saveBankQ <= decodeBank(stateQ);
        loadBankQ <= decodeBank(maskedVal);
      end else if (busyQ) begin
        if (stepQ == LAST_STEP) begin
          busyQ <= 1'b0;
          stepQ <= '0;
        end else begin
          stepQ <= stepQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    savePhase        = stepQ < HALF_STEP;
    stepOff          = stepQ - HALF_STEP;
    stepIdx          = savePhase ? IDX_W'(stepQ) : IDX_W'(stepOff);
    strobes.saveEn   = busyQ && savePhase;
    strobes.loadEn   = busyQ && !savePhase;
    strobes.saveBank = saveBankQ;
    strobes.loadBank = loadBankQ;
  end

  assign busy    = busyQ;
  assign curBank = decodeBank(stateQ);

  AST_STATE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ & ~STATE_KEEP) == '0); // R1

  AST_ALT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    accept && altDisable |=> !stateQ[ALT_BIT]); // R4

  AST_SAME_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    accept && (newSel == oldSel) |=> !busyQ); // R5

  AST_SWITCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startSwitch |=> busyQ); // R7

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(stepQ) == LAST_STEP); // R7

  AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && stateWrEn |=> $stable(stateQ)); // R8

endmodule

// File: rtl/gbank_dpath.sv
module gbank_dpath
  import gbank_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [IDX_W-1:0] stepIdx,
  input  logic             busy,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regWrIdx,
  input  logic [REG_W-1:0] regWrData,
  input  logic [IDX_W-1:0] regRdIdx,
  output logic [REG_W-1:0] regRdData
);

  logic [NUM_REGS-1:0][REG_W-1:0] activeQ;
  logic [NUM_REGS-1:0][REG_W-1:0] bankQ [NUM_BANKS];
  logic [REG_W-1:0]               loadData;

  assign loadData = bankQ[int'(strobes.loadBank)][stepIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= '0;
    end else if (strobes.loadEn) begin
      activeQ[stepIdx] <= loadData;
    end else if (regWrEn && !busy) begin
      activeQ[regWrIdx] <= regWrData;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[b] <= '0;
      end else if (strobes.saveEn && (int'(strobes.saveBank) == b)) begin
        bankQ[b][stepIdx] <= activeQ[stepIdx];
      end
    end
  end

  assign regRdData = activeQ[regRdIdx];

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.saveEn && strobes.loadEn)); // R6

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobes.loadEn |=> $stable(activeQ)); // R8

  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && regWrEn |=> activeQ[$past(regWrIdx)] == $past(regWrData)); // R10

endmodule

// File: rtl/gbank_switch.sv
module gbank_switch
  import gbank_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stateWrEn,
  input  logic [STATE_W-1:0] stateWrData,
  input  logic               altDisable,
  output logic [STATE_W-1:0] stateRd,
  output logic [1:0]         activeBank,
  output logic               busy,
  input  logic               regWrEn,
  input  logic [IDX_W-1:0]   regWrIdx,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [IDX_W-1:0]   regRdIdx,
  output logic [REG_W-1:0]   regRdData
);

  strobe_t          strobes;
  logic [IDX_W-1:0] stepIdx;
  bank_e            curBank;

  gbank_ctrl #(.NUM_REGS(NUM_REGS)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stateWrEn  (stateWrEn),
    .stateWrData(stateWrData),
    .altDisable (altDisable),
    .stateQ     (stateRd),
    .curBank    (curBank),
    .busy       (busy),
    .strobes    (strobes),
    .stepIdx    (stepIdx)
  );

  gbank_dpath #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stepIdx  (stepIdx),
    .busy     (busy),
    .regWrEn  (regWrEn),
    .regWrIdx (regWrIdx),
    .regWrData(regWrData),
    .regRdIdx (regRdIdx),
    .regRdData(regRdData)
  );

  assign activeBank = 2'(curBank);

endmodule

// File: tb/test_gbank_switch.sv
module test_gbank_switch;

  localparam int REG_W = 64;
  localparam int NREGS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stateWrEn = 1'b0;
  logic [11:0] stateWrData = '0;
  logic        altDisable = 1'b0;
  logic [11:0] stateRd;
  logic [1:0]  activeBank;
  logic        busy;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrIdx = '0;
  logic [63:0] regWrData = '0;
  logic [2:0]  regRdIdx = '0;
  logic [63:0] regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] modelActive [NREGS];
  logic [63:0] modelBank   [4][NREGS];
  logic [11:0] modelState;

  logic [63:0] expQ [$];
  int          kindQ [$];
  string       tagQ [$];
  logic        probeValid = 1'b0;

  always #10 clk = ~clk;

  gbank_switch i_gbank_switch (
    .clk(clk), .rstN(rstN), .stateWrEn(stateWrEn), .stateWrData(stateWrData),
    .altDisable(altDisable), .stateRd(stateRd), .activeBank(activeBank), .busy(busy),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .regRdIdx(regRdIdx), .regRdData(regRdData)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int bankOf(logic [11:0] s);
    if (s[0] && !s[10] && !s[11]) return 1;
    if (!s[0] && s[10] && !s[11]) return 2;
    if (!s[0] && !s[10] && s[11]) return 3;
    return 0;
  endfunction

  // monitor: pops one expectation per probed cycle
  always @(negedge clk) begin
    if (probeValid && expQ.size() > 0) begin
      logic [63:0] e;
      int k;
      string t;
      logic [63:0] a;
      e = expQ.pop_front();
      k = kindQ.pop_front();
      t = tagQ.pop_front();
      case (k)
        0: a = regRdData;
        1: a = 64'(stateRd);
        2: a = 64'(activeBank);
        default: a = 64'(busy);
      endcase
      check(t, a, e);
    end
  end

  task automatic probe(int kind, logic [2:0] idx, logic [63:0] exp, string tag);
    @(posedge clk); #1;
    regRdIdx = idx;
    expQ.push_back(exp);
    kindQ.push_back(kind);
    tagQ.push_back(tag);
    probeValid = 1'b1;
    @(posedge clk); #1;
    probeValid = 1'b0;
  endtask

  task automatic probeAll(string tag);
    for (int i = 0; i < NREGS; i++) probe(0, 3'(i), modelActive[i], {tag, " reg"});
    probe(1, 3'd0, 64'(modelState), {tag, " state"});
    probe(2, 3'd0, 64'(bankOf(modelState)), {tag, " bank"});
  endtask

  task automatic writeReg(int idx, logic [63:0] val);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrIdx = 3'(idx); regWrData = val;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    modelActive[idx] = val;
  endtask

  task automatic writeState(logic [11:0] d, bit poke, string tag);
    logic [11:0] m;
    bit sw;
    int n;
    m = d & 12'hF3F;
    if (altDisable) m[0] = 1'b0;
    sw = (m & 12'hC01) != (modelState & 12'hC01);
    if (sw) begin
      int ob;
      int nb;
      ob = bankOf(modelState);
      nb = bankOf(m);
      for (int i = 0; i < NREGS; i++) modelBank[ob][i] = modelActive[i];
      for (int i = 0; i < NREGS; i++) modelActive[i] = modelBank[nb][i];
    end
    modelState = m;
    @(posedge clk); #1;
    stateWrEn = 1'b1; stateWrData = d;
    @(posedge clk); #1;
    stateWrEn = 1'b0;
    if (!sw) begin
      check({tag, " R5 no busy on equal select"}, 64'(busy), 64'd0);
    end else begin
      n = 0;
      while (busy === 1'b1 && n < 100) begin
        if (poke && n == 2) begin
          regWrEn = 1'b1; regWrIdx = 3'd0; regWrData = 64'hDEAD_0000_BEEF_0000;
          stateWrEn = 1'b1; stateWrData = 12'h001;
        end
        if (poke && n == 3) begin
          regWrEn = 1'b0; stateWrEn = 1'b0;
        end
        n++;
        @(posedge clk); #1;
      end
      regWrEn = 1'b0; stateWrEn = 1'b0;
      check({tag, " R7 busy length"}, 64'(n), 64'(2 * NREGS));
    end
  endtask

  initial begin
    modelState = '0;
    for (int i = 0; i < NREGS; i++) begin
      modelActive[i] = '0;
      for (int b = 0; b < 4; b++) modelBank[b][i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check("R9 busy after reset", 64'(busy), 64'd0);
    probeAll("R9 reset");

    for (int i = 0; i < NREGS; i++) writeReg(i, 64'hA5A5_0000_0000_0000 | 64'(i * 17 + 3));
    probeAll("R10 pattern A");

    writeState(12'h001, 1'b0, "R2 alt");
    probeAll("R6 R2 enter alt");

    for (int i = 0; i < NREGS; i++) writeReg(i, ~(64'h1111 << i));
    writeState(12'h400, 1'b0, "R2 mmu");
    probeAll("R6 R2 enter mmu");

    writeState(12'h000, 1'b0, "R6 normal");
    probeAll("R6 round trip normal");

    writeState(12'hFFF, 1'b0, "R3 invalid");
    probeAll("R3 R1 invalid select");

    writeState(12'h0C0, 1'b0, "R1 masked");
    probeAll("R1 masked bits");

    writeState(12'h13E, 1'b0, "R5 equal");
    probeAll("R5 equal select");

    altDisable = 1'b1;
    writeState(12'h001, 1'b0, "R4 alt off");
    probeAll("R4 alt bit dropped");

    writeState(12'h801, 1'b1, "R8 intr");
    probeAll("R8 R4 R2 intr after stall");

    altDisable = 1'b0;
    writeState(12'h001, 1'b0, "R6 alt again");
    probeAll("R6 alt restore");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule